// File: doc/BRIEF.md
# Conversion Setup Sequencer

This block sits between the register file of a multi-channel delta-sigma converter and its conversion engine. When a conversion command is executed, it takes a 32-bit setup register, picks the 16-bit half that belongs to the addressed setup, and decodes the fields in that half. From them it loads the two external latch pins and the input polarity mode. It also loads the open-circuit test current enable and the index of the offset/gain calibration set to apply. Finally it releases a one-cycle conversion-start strobe, either right away or after a settling wait counted in master-clock cycles.

Two configuration bits can override the setup word. The latch-source bit replaces the latch field with an alternate 2-bit value. The pointer-source bit chooses between the word's own calibration pointer and the physical channel index. A third configuration bit, the rate select, sets the length of the settling wait. All ports are plain control or status signals. No data stream crosses the block edge, so it has no valid/ready pair and applies no back-pressure. A command is a one-cycle strobe that is always accepted.

Top module: `conv_setup_seq`

## Requirements
- R1: On a command, `unipolar` loads bit 6 of the selected half, and it is visible after the clock edge that samples the command. A 0 in that bit selects bipolar mode (`unipolar`=0) and a 1 selects unipolar mode (`unipolar`=1).
- R2: With `hi_half`=1 the fields come from bits 31:16 of `setup_word`, so the polarity bit is bit 22. With `hi_half`=0 they come from bits 15:0.
- R3: On a command with `cfg_latch_sel`=0, the 2-bit latch field (bits 5:4 of the half) drives the pins. Bit 5 goes to `pin_a0` and bit 4 goes to `pin_a1`, so 01 gives A0=0,A1=1 and 10 gives A0=1,A1=0.
- R4: On a command with `cfg_latch_sel`=1, the latch field is ignored. `pin_a0` takes `alt_latch[1]` and `pin_a1` takes `alt_latch[0]`.
- R5: Without a command, `pin_a0`, `pin_a1`, `unipolar`, `ocd_en` and `calset` keep their values, even when the setup and configuration inputs change.
- R6: When bit 3 of the half is 0, `conv_start` is high for exactly one cycle, directly after the edge that samples the command.
- R7: When bit 3 is 1 and `cfg_rate_sel`=0, the start pulse comes exactly 1280 cycles later than an immediate one would.
- R8: When bit 3 is 1 and `cfg_rate_sel`=1, the start pulse comes exactly 1536 cycles later than an immediate one would.
- R9: With `cfg_ptr_sel`=1, `calset` loads the pointer field (bits 1:0 of the half). With `cfg_ptr_sel`=0 it loads `chan_idx`. The value 0..3 names calibration set 1..4.
- R10: On a command, `ocd_en` loads bit 2 of the half: 1 turns the test current source on and 0 means normal operation.
- R11: `busy` is high from the cycle after a command through the cycle of its start pulse, and low in the cycle after that pulse.
- R12: A command arriving during a settling wait abandons that wait and restarts timing from the new command. Only one start pulse follows, placed by the new command's delay.
- R13: Synchronous active-high `rst` clears `pin_a0`, `pin_a1`, `busy`, `conv_start`, `unipolar`, `ocd_en`, `calset` and the wait counter. A wait that was in progress then produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_go | input | 1 | One-cycle conversion command strobe |
| setup_word | input | 32 | Setup register holding two setup halves |
| hi_half | input | 1 | 1 selects bits 31:16, 0 selects bits 15:0 |
| chan_idx | input | 2 | Physical channel of the addressed setup |
| cfg_latch_sel | input | 1 | 1 takes latch pins from `alt_latch` |
| cfg_ptr_sel | input | 1 | 1 takes calibration set from the pointer field |
| cfg_rate_sel | input | 1 | Selects 1280 (0) or 1536 (1) cycle wait |
| alt_latch | input | 2 | Alternate latch pin value {A0,A1} |
| pin_a0 | output | 1 | Latch output pin A0 |
| pin_a1 | output | 1 | Latch output pin A1 |
| unipolar | output | 1 | 1 = unipolar, 0 = bipolar |
| ocd_en | output | 1 | Open-circuit test current enable |
| calset | output | 2 | Offset/gain set index (0..3 = set 1..4) |
| busy | output | 1 | Command accepted, start not yet issued |
| conv_start | output | 1 | One-cycle conversion start strobe |

## Verification
The bench measures the exact start cycle for both wait lengths and for an immediate start. A counter that is off by one, or that picks the wrong rate, gives a pulse one cycle early or late, or 256 cycles off. It fires a second command in the middle of a wait. A sequencer that does not restart would emit a stray early pulse, which the scoreboard flags as unexpected. It drives upper and lower halves that carry different contents, and it sets both override bits each way. A swapped half, swapped latch bits or a wrong override source then shows up as wrong pins or a wrong calibration index at the pulse. It also changes the inputs with no command and asserts reset during a wait, so outputs that leak through or a pulse that survives reset get caught.

// File: rtl/conv_setup_pkg.sv
package conv_setup_pkg;

  localparam int HALF_W = 16;

  // Field positions inside one setup half-word
  localparam int POS_POL  = 6;
  localparam int POS_LAT  = 4;
  localparam int POS_DLY  = 3;
  localparam int POS_OCD  = 2;
  localparam int POS_PTR  = 0;

  typedef struct packed {
    logic       unipolar;
    logic [1:0] latch;     // {A0, A1}
    logic       delay;
    logic       ocd;
    logic [1:0] ptr;
  } setup_fields_t;

endpackage

// File: rtl/setup_field_decode.sv
module setup_field_decode
  import conv_setup_pkg::*;
#(
  parameter int WORD_W = 2 * HALF_W
) (
  input  logic [WORD_W-1:0] setup_word,
  input  logic              hi_half,
  output setup_fields_t     fields
);
  localparam int HW = WORD_W / 2;

  logic [HW-1:0] half;

  always_comb begin
    half = hi_half ? setup_word[WORD_W-1:HW] : setup_word[HW-1:0];
    fields.unipolar = half[POS_POL];
    fields.latch    = half[POS_LAT+1:POS_LAT];
    fields.delay    = half[POS_DLY];
    fields.ocd      = half[POS_OCD];
    fields.ptr      = half[POS_PTR+1:POS_PTR];
  end
endmodule

// File: rtl/latch_pin_ctrl.sv
module latch_pin_ctrl (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic       src_alt,
  input  logic [1:0] field_val,
  input  logic [1:0] alt_val,
  output logic       pin_a0,
  output logic       pin_a1
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pin_a0 <= 1'b0;
      pin_a1 <= 1'b0;
    end else if (load) begin
      if (src_alt) begin
        pin_a0 <= alt_val[1];
        pin_a1 <= alt_val[0];
      end else begin
        pin_a0 <= field_val[1];
        pin_a1 <= field_val[0];
      end
    end
  end

  assert_latch_field_R3: assert property (@(posedge clk) disable iff (rst)
    (load && !src_alt) |=> ({pin_a0, pin_a1} == $past(field_val)));

  assert_latch_alt_R4: assert property (@(posedge clk) disable iff (rst)
    (load && src_alt) |=> ({pin_a0, pin_a1} == $past(alt_val)));

  assert_latch_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable({pin_a0, pin_a1}));
endmodule

// File: rtl/calset_select.sv
module calset_select #(
  parameter int SET_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             use_ptr,
  input  logic [SET_W-1:0] ptr_val,
  input  logic [SET_W-1:0] chan_val,
  output logic [SET_W-1:0] calset
);
  always_ff @(posedge clk) begin
    if (rst)       calset <= '0;
    else if (load) calset <= use_ptr ? ptr_val : chan_val;
  end

  assert_calset_ptr_R9: assert property (@(posedge clk) disable iff (rst)
    (load && use_ptr) |=> (calset == $past(ptr_val)));

  assert_calset_chan_R9: assert property (@(posedge clk) disable iff (rst)
    (load && !use_ptr) |=> (calset == $past(chan_val)));

  assert_calset_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(calset));
endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
  parameter int DLY_RATE0 = 1280,
  parameter int DLY_RATE1 = 1536
) (
  input  logic clk,
  input  logic rst,
  input  logic go,
  input  logic want_delay,
  input  logic rate_sel,
  output logic busy,
  output logic start_pulse
);
  localparam int DLY_MAX = (DLY_RATE0 > DLY_RATE1) ? DLY_RATE0 : DLY_RATE1;
  localparam int CNT_W   = $clog2(DLY_MAX + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] load_val;

  always_comb begin
    load_val = rate_sel ? CNT_W'(DLY_RATE1) : CNT_W'(DLY_RATE0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt         <= '0;
      busy        <= 1'b0;
      start_pulse <= 1'b0;
    end else if (go) begin
      busy        <= 1'b1;
      cnt         <= want_delay ? load_val : '0;
      start_pulse <= !want_delay;
    end else begin
      start_pulse <= (cnt == CNT_W'(1));
      if (cnt != '0) cnt <= cnt - 1'b1;
      if (start_pulse) busy <= 1'b0;
    end
  end

  assert_start_single_R6: assert property (@(posedge clk) disable iff (rst)
    (start_pulse && !go) |=> !start_pulse);

  assert_start_immediate_R6: assert property (@(posedge clk) disable iff (rst)
    (go && !want_delay) |=> start_pulse);

  assert_delay_not_early_R7: assert property (@(posedge clk) disable iff (rst)
    (go && want_delay) |=> (!start_pulse && busy));

  assert_busy_at_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    start_pulse |-> busy);

  assert_busy_drop_R11: assert property (@(posedge clk) disable iff (rst)
    (start_pulse && !go) |=> !busy);

  assert_counting_busy_R12: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0) |-> busy);
endmodule

// File: rtl/conv_setup_seq.sv
module conv_setup_seq
  import conv_setup_pkg::*;
#(
  parameter int DLY_RATE0 = 1280,
  parameter int DLY_RATE1 = 1536,
  parameter int CHAN_W    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_go,
  input  logic [31:0]       setup_word,
  input  logic              hi_half,
  input  logic [CHAN_W-1:0] chan_idx,
  input  logic              cfg_latch_sel,
  input  logic              cfg_ptr_sel,
  input  logic              cfg_rate_sel,
  input  logic [1:0]        alt_latch,
  output logic              pin_a0,
  output logic              pin_a1,
  output logic              unipolar,
  output logic              ocd_en,
  output logic [CHAN_W-1:0] calset,
  output logic              busy,
  output logic              conv_start
);
  setup_fields_t fields;

  setup_field_decode #(.WORD_W(32)) u_decode (
    .setup_word (setup_word),
    .hi_half    (hi_half),
    .fields     (fields)
  );

  latch_pin_ctrl u_latch (
    .clk       (clk),
    .rst       (rst),
    .load      (cmd_go),
    .src_alt   (cfg_latch_sel),
    .field_val (fields.latch),
    .alt_val   (alt_latch),
    .pin_a0    (pin_a0),
    .pin_a1    (pin_a1)
  );

  calset_select #(.SET_W(CHAN_W)) u_calset (
    .clk      (clk),
    .rst      (rst),
    .load     (cmd_go),
    .use_ptr  (cfg_ptr_sel),
    .ptr_val  (CHAN_W'(fields.ptr)),
    .chan_val (chan_idx),
    .calset   (calset)
  );

  settle_timer #(.DLY_RATE0(DLY_RATE0), .DLY_RATE1(DLY_RATE1)) u_timer (
    .clk         (clk),
    .rst         (rst),
    .go          (cmd_go),
    .want_delay  (fields.delay),
    .rate_sel    (cfg_rate_sel),
    .busy        (busy),
    .start_pulse (conv_start)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      unipolar <= 1'b0;
      ocd_en   <= 1'b0;
    end else if (cmd_go) begin
      unipolar <= fields.unipolar;
      ocd_en   <= fields.ocd;
    end
  end

  assert_polarity_R1: assert property (@(posedge clk) disable iff (rst)
    cmd_go |=> (unipolar == $past(hi_half ? setup_word[22] : setup_word[6])));

  assert_ocd_R10: assert property (@(posedge clk) disable iff (rst)
    cmd_go |=> (ocd_en == $past(hi_half ? setup_word[18] : setup_word[2])));

  assert_mode_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !cmd_go |=> $stable({unipolar, ocd_en}));
endmodule

// File: tb/test_conv_setup_seq.sv
module test_conv_setup_seq;
  localparam int CLK_PERIOD = 10;
  localparam int D0 = 1280;
  localparam int D1 = 1536;
  localparam longint WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_go = 1'b0;
  logic [31:0] setup_word = '0;
  logic hi_half = 1'b0;
  logic [1:0] chan_idx = '0;
  logic cfg_latch_sel = 1'b0, cfg_ptr_sel = 1'b0, cfg_rate_sel = 1'b0;
  logic [1:0] alt_latch = '0;
  logic pin_a0, pin_a1, unipolar, ocd_en, busy, conv_start;
  logic [1:0] calset;

  conv_setup_seq i_conv_setup_seq (
    .clk(clk), .rst(rst), .cmd_go(cmd_go), .setup_word(setup_word),
    .hi_half(hi_half), .chan_idx(chan_idx), .cfg_latch_sel(cfg_latch_sel),
    .cfg_ptr_sel(cfg_ptr_sel), .cfg_rate_sel(cfg_rate_sel), .alt_latch(alt_latch),
    .pin_a0(pin_a0), .pin_a1(pin_a1), .unipolar(unipolar), .ocd_en(ocd_en),
    .calset(calset), .busy(busy), .conv_start(conv_start)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    longint     at;
    logic       a0, a1, uni, ocd;
    logic [1:0] cs;
    string      tag;
  } exp_t;

  exp_t   sb[$];
  longint cyc = 0;
  int     n_chk = 0, n_bad = 0;
  logic   busy_was_pulse = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Monitor: compare start pulses against the scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (busy_was_pulse && !cmd_go)
        chk(busy == 1'b0, "R11 busy after pulse", busy, 0);
      busy_was_pulse <= conv_start;
      if (conv_start) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R12/R13 unexpected start pulse", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(cyc == e.at, {e.tag, " start cycle"}, cyc, e.at);
          chk({pin_a0, pin_a1} == {e.a0, e.a1}, {e.tag, " R3/R4 latch pins"}, {pin_a0, pin_a1}, {e.a0, e.a1});
          chk(unipolar == e.uni, {e.tag, " R1 polarity"}, unipolar, e.uni);
          chk(ocd_en == e.ocd, {e.tag, " R10 ocd"}, ocd_en, e.ocd);
          chk(calset == e.cs, {e.tag, " R9 calset"}, calset, e.cs);
          chk(busy == 1'b1, {e.tag, " R11 busy at pulse"}, busy, 1);
        end
      end
    end
  end

  task automatic issue(input logic [31:0] w, input logic hi, input logic [1:0] ch,
                       input logic ls, input logic ps, input logic rs,
                       input logic [1:0] alt, input bit push, input string tag);
    logic [15:0] h;
    exp_t e;
    @(negedge clk);
    setup_word = w; hi_half = hi; chan_idx = ch;
    cfg_latch_sel = ls; cfg_ptr_sel = ps; cfg_rate_sel = rs; alt_latch = alt;
    cmd_go = 1'b1;
    h = hi ? w[31:16] : w[15:0];       // R2
    e.at  = cyc + 1 + (h[3] ? (rs ? D1 : D0) : 0);
    e.a0  = ls ? alt[1] : h[5];
    e.a1  = ls ? alt[0] : h[4];
    e.uni = h[6];
    e.ocd = h[2];
    e.cs  = ps ? h[1:0] : ch;
    e.tag = tag;
    if (push) sb.push_back(e);
    @(negedge clk);
    cmd_go = 1'b0;
  endtask

  task automatic drain();
    int k;
    k = 0;
    while (sb.size() != 0 && k < 2000) begin
      @(negedge clk);
      k++;
    end
    chk(sb.size() == 0, "pulse missing", sb.size(), 0);
    sb.delete();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [1:0] p_pins, p_cs;
    logic p_uni, p_ocd;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R13 reset state
    chk({pin_a0, pin_a1, busy, conv_start, unipolar, ocd_en} == 6'b0, "R13 reset outputs",
        {pin_a0, pin_a1, busy, conv_start, unipolar, ocd_en}, 0);
    chk(calset == 2'd0, "R13 reset calset", calset, 0);

    // R6 immediate, lower half, pointer select, R2 upper half differs
    issue(32'h001B_0067, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 2'b00, 1, "R6 R2 lower");
    drain();
    // R2 upper half
    issue(32'h0056_0019, 1'b1, 2'd2, 1'b0, 1'b1, 1'b0, 2'b00, 1, "R2 upper");
    drain();
    // R4 alternate latch source
    issue(32'h0000_0030, 1'b0, 2'd1, 1'b1, 1'b0, 1'b0, 2'b10, 1, "R4 alt 10");
    drain();
    issue(32'h0000_0020, 1'b0, 2'd1, 1'b1, 1'b0, 1'b0, 2'b01, 1, "R4 alt 01");
    drain();
    // R9 channel index when pointer select is 0
    issue(32'h0000_0012, 1'b0, 2'd3, 1'b0, 1'b0, 1'b0, 2'b00, 1, "R9 chan");
    drain();
    // R7 / R8 delays
    issue(32'h0000_0048, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 2'b00, 1, "R7 rate0");
    drain();
    issue(32'h0008_0000, 1'b1, 2'd1, 1'b0, 1'b1, 1'b1, 2'b00, 1, "R8 rate1");
    drain();
    // R12 restart during wait
    issue(32'h0000_0038, 1'b0, 2'd0, 1'b0, 1'b1, 1'b1, 2'b00, 0, "R12 first");
    repeat (100) @(negedge clk);
    chk(busy == 1'b1, "R11 busy during wait", busy, 1);
    issue(32'h0000_004D, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 2'b00, 1, "R12 restart");
    drain();
    repeat (D1) @(negedge clk);   // no stray pulse from the first command
    // R5 hold without command
    p_pins = {pin_a0, pin_a1}; p_cs = calset; p_uni = unipolar; p_ocd = ocd_en;
    @(negedge clk);
    setup_word = ~setup_word; alt_latch = ~alt_latch; chan_idx = ~chan_idx;
    cfg_latch_sel = ~cfg_latch_sel; cfg_ptr_sel = ~cfg_ptr_sel; hi_half = ~hi_half;
    repeat (5) @(negedge clk);
    chk({pin_a0, pin_a1} == p_pins, "R5 pins hold", {pin_a0, pin_a1}, p_pins);
    chk(calset == p_cs, "R5 calset hold", calset, p_cs);
    chk({unipolar, ocd_en} == {p_uni, p_ocd}, "R5 mode hold", {unipolar, ocd_en}, {p_uni, p_ocd});
    chk(conv_start == 1'b0 && busy == 1'b0, "R5 no start", conv_start, 0);
    // R13 reset during wait kills the pulse
    issue(32'h0000_0008, 1'b0, 2'd2, 1'b0, 1'b0, 1'b0, 2'b11, 0, "R13 mid");
    repeat (20) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0 && calset == 2'd0, "R13 reset mid-wait", {busy, calset}, 0);
    repeat (D0 + 10) @(negedge clk);
    // Mixed patterns
    for (int i = 0; i < 24; i++) begin
      logic [31:0] w;
      w = $urandom;
      if (i % 4 != 3) begin
        w[19] = 1'b0;
        w[3]  = 1'b0;
      end
      issue(w, logic'(i[0]), 2'(i), logic'(i[1]), logic'(i[2]), logic'(i[3]),
            2'(i >> 1), 1, "R1 R3 R10 mixed");
      drain();
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule